// File: doc/BRIEF.md
# Dual-Mode Receive Bus Capture

This block sits between a serial-link PHY and the link layer of a MAC. It takes the PHY's parallel receive bus and turns it into one uniform word of two 8-bit symbols, each with its own data/control flag, plus a valid strobe. All outputs are in the rising-edge domain of the receive clock. The receive clock also serves as the block's only working clock.

The receive bus runs in one of two widths, chosen by a strap. In the wide form, the PHY drives 16 data bits and two flags, and both symbols arrive on every rising edge. In the narrow form, the PHY drives 8 data bits and one flag on both clock edges. The block joins each rising-edge byte with the falling-edge byte that follows it. The link layer sees the same word layout either way: the older symbol sits in the low byte.

The strap is read once, at the first rising edge after reset is released. It then holds until the next reset. The valid strobe stays low until a complete word exists.

Top module: `rxcap_top`

## Requirements
- R1: The mode strap is sampled at the first rising clock edge after the active-low reset is released. Strap low selects single-data-rate capture and strap high selects double-data-rate capture.
- R2: Strap changes after that first rising edge have no effect on the capture mode until reset is asserted again.
- R3: The valid output is 0 while reset is asserted, and it drops at once when reset asserts. It stays 0 after the first rising edge after release. From the second rising edge on, it is 1 after every rising edge.
- R4: In single-data-rate mode, the 16-bit bus value present at a rising edge appears on the word output after that edge. Bits [7:0] hold the first symbol and bits [15:8] hold the second symbol.
- R5: In single-data-rate mode, input flag 0 goes to output flag 0 and qualifies word bits [7:0]. Input flag 1 goes to output flag 1 and qualifies bits [15:8]. A flag of 0 marks data and a flag of 1 marks a control character.
- R6: In double-data-rate mode, the byte on bus bits [7:0] at a rising edge becomes word bits [7:0]. The byte on bits [7:0] at the following falling edge becomes word bits [15:8]. The pair appears after the next rising edge.
- R7: In double-data-rate mode, input flag 0 sampled at the rising edge becomes output flag 0. Input flag 0 sampled at the following falling edge becomes output flag 1.
- R8: In double-data-rate mode, bus bits [15:8] and input flag 1 have no effect on any output.
- R9: While reset is asserted, the word and both output flags are 0.
- R10: In single-data-rate mode, bus values that change between rising edges are not captured. Only the value present at the rising edge reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | Receive clock, also the working clock |
| i_rst_n | input | 1 | Asynchronous active-low reset, released in step with i_clk |
| i_ddr_sel | input | 1 | Mode strap: 0 selects single-data-rate, 1 selects double-data-rate |
| i_bus_data | input | 16 | Receive data bus from the PHY |
| i_bus_k | input | 2 | Per-byte data/control flags from the PHY |
| o_word | output | 16 | Assembled word: first symbol in [7:0], second symbol in [15:8] |
| o_word_k | output | 2 | Per-symbol control flags for o_word |
| o_word_vld | output | 1 | Word valid strobe |

## Verification
The hardest case to reach from the ports is double-data-rate pairing. Here one output word is built from two bus values that exist only in opposite half-cycles, while bits [15:8] carry other values in each half. The bench drives the rising-edge byte shortly after each falling edge and the falling-edge byte shortly after each rising edge. It fills the upper lane with inverted garbage in both halves. As a result, any wrong pairing, swapped order or leak from the upper lane shows up as a different word one edge later. The strap is also flipped in the middle of a double-data-rate run, to show the latched mode holds.

// File: rtl/rxcap_pkg.sv
`timescale 1ns/1ps
package rxcap_pkg;
  // Number of symbols carried in one output word; pairing logic assumes two.
  localparam int unsigned SYMS_PER_WORD = 2;

  typedef enum logic {
    MODE_SDR = 1'b0,
    MODE_DDR = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/rxcap_strap.sv
`timescale 1ns/1ps
// Latches the mode strap on the first rising edge after reset release and
// reports when the capture path is running.
module rxcap_strap
  import rxcap_pkg::*;
(
  input  logic      i_clk,
  input  logic      i_rst_n,
  input  logic      i_strap,
  output cap_mode_e o_mode,
  output logic      o_run
);
  cap_mode_e mode_q, mode_d;
  logic      start_q, start_d;

  always_comb begin
    mode_d  = mode_q;
    start_d = 1'b0;
    if (start_q) begin
      mode_d = cap_mode_e'(i_strap);
    end
  end

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      mode_q  <= MODE_SDR;
      start_q <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      start_q <= start_d;
    end
  end

  assign o_mode = mode_q;
  assign o_run  = !start_q;
endmodule

// File: rtl/rxcap_fall_reg.sv
`timescale 1ns/1ps
// Negative-edge capture register with clock enable; read only through q.
module rxcap_fall_reg #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             i_clk,
  input  logic             i_rst_n,
  input  logic             i_en,
  input  logic [WIDTH-1:0] i_d,
  output logic [WIDTH-1:0] o_q
);
  logic [WIDTH-1:0] q_r, d_r;

  always_comb begin
    d_r = q_r;
    if (i_en) begin
      d_r = i_d;
    end
  end

  always_ff @(negedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= d_r;
    end
  end

  assign o_q = q_r;
endmodule

// File: rtl/rxcap_assemble.sv
`timescale 1ns/1ps
// Rising-edge half: holds the first DDR symbol and registers the output word.
module rxcap_assemble
  import rxcap_pkg::*;
#(
  parameter int unsigned SYM_W = 8
) (
  input  logic                              i_clk,
  input  logic                              i_rst_n,
  input  logic                              i_run,
  input  cap_mode_e                         i_mode,
  input  logic [SYMS_PER_WORD*SYM_W-1:0]    i_bus_data,
  input  logic [SYMS_PER_WORD-1:0]          i_bus_k,
  input  logic [SYM_W-1:0]                  i_fall_sym,
  input  logic                              i_fall_k,
  output logic [SYMS_PER_WORD*SYM_W-1:0]    o_word,
  output logic [SYMS_PER_WORD-1:0]          o_word_k,
  output logic                              o_vld
);
  localparam int unsigned WORD_W = SYMS_PER_WORD * SYM_W;

  logic [SYM_W-1:0] rise_sym_q, rise_sym_d;
  logic             rise_k_q, rise_k_d;
  logic             rise_en;

  logic [SYMS_PER_WORD-1:0][SYM_W-1:0] sdr_sym;
  logic [SYMS_PER_WORD-1:0][SYM_W-1:0] ddr_sym;
  logic [SYMS_PER_WORD-1:0]            ddr_k;

  logic [WORD_W-1:0]        word_q, word_d;
  logic [SYMS_PER_WORD-1:0] k_q, k_d;
  logic                     vld_q, vld_d;
  logic                     out_en;

  // Split the wide bus into symbols, lowest lane first.
  for (genvar s = 0; s < SYMS_PER_WORD; s++) begin : g_sdr_lane
    assign sdr_sym[s] = i_bus_data[s*SYM_W +: SYM_W];
  end

  // Older symbol (rising edge) in lane 0, newer (falling edge) in lane 1.
  assign ddr_sym[0] = rise_sym_q;
  assign ddr_sym[1] = i_fall_sym;
  assign ddr_k      = {i_fall_k, rise_k_q};

  // The first-symbol holder also loads on the strap edge, so the first
  // DDR pair is complete one edge later.
  assign rise_en = !i_run || (i_mode == MODE_DDR);
  assign out_en  = i_run;

  always_comb begin
    rise_sym_d = rise_sym_q;
    rise_k_d   = rise_k_q;
    if (rise_en) begin
      rise_sym_d = i_bus_data[SYM_W-1:0];
      rise_k_d   = i_bus_k[0];
    end
  end

  always_comb begin
    word_d = word_q;
    k_d    = k_q;
    vld_d  = 1'b0;
    if (out_en) begin
      vld_d = 1'b1;
      if (i_mode == MODE_DDR) begin
        word_d = ddr_sym;
        k_d    = ddr_k;
      end else begin
        word_d = sdr_sym;
        k_d    = i_bus_k;
      end
    end
  end

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      rise_sym_q <= '0;
      rise_k_q   <= 1'b0;
      word_q     <= '0;
      k_q        <= '0;
      vld_q      <= 1'b0;
    end else begin
      rise_sym_q <= rise_sym_d;
      rise_k_q   <= rise_k_d;
      word_q     <= word_d;
      k_q        <= k_d;
      vld_q      <= vld_d;
    end
  end

  assign o_word   = word_q;
  assign o_word_k = k_q;
  assign o_vld    = vld_q;
endmodule

// File: rtl/rxcap_top.sv
`timescale 1ns/1ps
module rxcap_top
  import rxcap_pkg::*;
#(
  parameter int unsigned SYM_W = 8
) (
  input  logic                           i_clk,
  input  logic                           i_rst_n,
  input  logic                           i_ddr_sel,
  input  logic [SYMS_PER_WORD*SYM_W-1:0] i_bus_data,
  input  logic [SYMS_PER_WORD-1:0]       i_bus_k,
  output logic [SYMS_PER_WORD*SYM_W-1:0] o_word,
  output logic [SYMS_PER_WORD-1:0]       o_word_k,
  output logic                           o_word_vld
);
  localparam int unsigned FALL_W = SYM_W + 1;

  cap_mode_e         mode_w;
  logic              run_w;
  logic              fall_en;
  logic [FALL_W-1:0] fall_q;

  rxcap_strap u_strap (
    .i_clk   (i_clk),
    .i_rst_n (i_rst_n),
    .i_strap (i_ddr_sel),
    .o_mode  (mode_w),
    .o_run   (run_w)
  );

  assign fall_en = (mode_w == MODE_DDR);

  rxcap_fall_reg #(.WIDTH(FALL_W)) u_fall (
    .i_clk   (i_clk),
    .i_rst_n (i_rst_n),
    .i_en    (fall_en),
    .i_d     ({i_bus_k[0], i_bus_data[SYM_W-1:0]}),
    .o_q     (fall_q)
  );

  rxcap_assemble #(.SYM_W(SYM_W)) u_asm (
    .i_clk      (i_clk),
    .i_rst_n    (i_rst_n),
    .i_run      (run_w),
    .i_mode     (mode_w),
    .i_bus_data (i_bus_data),
    .i_bus_k    (i_bus_k),
    .i_fall_sym (fall_q[SYM_W-1:0]),
    .i_fall_k   (fall_q[SYM_W]),
    .o_word     (o_word),
    .o_word_k   (o_word_k),
    .o_vld      (o_word_vld)
  );
endmodule

// File: rtl/rxcap_chk.sv
`timescale 1ns/1ps
module rxcap_chk #(
  parameter int unsigned SYM_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strap,
  input logic               mode,
  input logic [2*SYM_W-1:0] bus_data,
  input logic [1:0]         bus_k,
  input logic [2*SYM_W-1:0] word,
  input logic [1:0]         word_k,
  input logic               vld
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RST_QUIET: assert (!vld && word == '0 && word_k == '0); // R9
    end
  end

  AST_STRAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |=> (mode == $past(strap))); // R1

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> $stable(mode)); // R2

  AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |=> !vld); // R3

  AST_VLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> vld); // R3

  AST_SDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !mode) |=> (word == $past(bus_data) && word_k == $past(bus_k))); // R4

  AST_DDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && mode) |=> (word[SYM_W-1:0] == $past(bus_data[SYM_W-1:0], 2)
                          && word_k[0] == $past(bus_k[0], 2))); // R6
endmodule

bind rxcap_top rxcap_chk #(.SYM_W(SYM_W)) u_chk (
  .clk      (i_clk),
  .rst_n    (i_rst_n),
  .strap    (i_ddr_sel),
  .mode     (mode_w),
  .bus_data (i_bus_data),
  .bus_k    (i_bus_k),
  .word     (o_word),
  .word_k   (o_word_k),
  .vld      (o_word_vld)
);

// File: tb/sim_rxcap_top.sv
`timescale 1ns/1ps
module sim_rxcap_top;
  logic        clk;
  logic        rst_n;
  logic        ddr_sel;
  logic [15:0] bus_data;
  logic [1:0]  bus_k;
  logic [15:0] word;
  logic [1:0]  word_k;
  logic        vld;

  int checks;
  int fails;

  // Each entry: {flags[1:0], data[15:0]}; expected word equals the entry.
  localparam int NVEC = 8;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b00, 16'h3412}, {2'b01, 16'h56BC}, {2'b10, 16'hFC78}, {2'b11, 16'hBC1C},
    {2'b00, 16'h0000}, {2'b00, 16'hFFFF}, {2'b01, 16'hF7FB}, {2'b10, 16'h9A5C}
  };
  localparam logic [17:0] DUMMY = {2'b10, 16'hA1B2};

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  rxcap_top u0 (
    .i_clk      (clk),
    .i_rst_n    (rst_n),
    .i_ddr_sel  (ddr_sel),
    .i_bus_data (bus_data),
    .i_bus_k    (bus_k),
    .o_word     (word),
    .o_word_k   (word_k),
    .o_word_vld (vld)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // One clock of stimulus: rising-edge value driven after the falling edge,
  // second-phase value driven after the rising edge. Returns just after the
  // rising edge, when the outputs of that edge are settled.
  task automatic step(input logic [17:0] v, input bit ddr);
    @(negedge clk); #1;
    if (ddr) begin
      bus_data = {~v[7:0], v[7:0]};
      bus_k    = {~v[16], v[16]};
    end else begin
      bus_data = v[15:0];
      bus_k    = v[17:16];
    end
    @(posedge clk); #1;
    if (ddr) begin
      bus_data = {v[7:0] ^ 8'h5A, v[15:8]};
      bus_k    = {~v[17], v[17]};
    end else begin
      bus_data = ~v[15:0];
      bus_k    = ~v[17:16];
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); #1;
    rst_n   = 1'b0;
    ddr_sel = strap;
    repeat (3) @(posedge clk);
    #1;
    check("R9 word in reset", {16'h0, word}, 32'h0);
    check("R9 flags in reset", {30'h0, word_k}, 32'h0);
    check("R3 vld in reset", {31'h0, vld}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [17:0] prev;
    checks   = 0;
    fails    = 0;
    rst_n    = 1'b0;
    ddr_sel  = 1'b0;
    bus_data = '0;
    bus_k    = '0;

    // ---- single-data-rate pass ----
    do_reset(1'b0);
    step(DUMMY, 1'b0);
    check("R3 vld after first edge", {31'h0, vld}, 32'h0);
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i], 1'b0);
      check("R3 vld running", {31'h0, vld}, 32'h1);
      check("R4 R10 sdr word", {16'h0, word}, {16'h0, VEC[i][15:0]});
      check("R5 sdr flags", {30'h0, word_k}, {30'h0, VEC[i][17:16]});
    end
    // Strap raised while running: SDR capture must continue (R2).
    ddr_sel = 1'b1;
    step(VEC[2], 1'b0);
    step(VEC[3], 1'b0);
    check("R2 sdr kept after strap change", {14'h0, word_k, word}, {14'h0, VEC[3]});

    // Asynchronous reset mid-run, away from any clock edge (R3, R9).
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    check("R3 vld drops on reset", {31'h0, vld}, 32'h0);
    check("R9 word clears on reset", {16'h0, word}, 32'h0);

    // ---- double-data-rate pass ----
    do_reset(1'b1);
    step(DUMMY, 1'b1);
    check("R3 vld after first edge ddr", {31'h0, vld}, 32'h0);
    prev = DUMMY;
    for (int i = 0; i < NVEC; i++) begin
      if (i == 4) ddr_sel = 1'b0;
      step(VEC[i], 1'b1);
      check(i == 0 ? "R1 ddr selected by strap" : "R6 R8 ddr word",
            {16'h0, word}, {16'h0, prev[15:0]});
      check(i >= 5 ? "R2 ddr kept after strap change" : "R7 ddr flags",
            {30'h0, word_k}, {30'h0, prev[17:16]});
      check("R3 vld running ddr", {31'h0, vld}, 32'h1);
      prev = VEC[i];
    end
    step(DUMMY, 1'b1);
    check("R6 last ddr pair", {14'h0, word_k, word}, {14'h0, prev});

    summary();
    $finish;
  end
endmodule